// File: doc/BRIEF.md
# Batched Weighted Reduction Stage

This block finishes a batched linear regression. An earlier stage leaves a matrix of partial sums in memory, with one row per batch item and one column per support vector. This block multiplies each partial sum by the coefficient of its support vector, adds up the products of each batch item, adds a bias, and emits one saturated result per item.

After a start pulse the block fetches one memory word per cycle. A word holds LANES adjacent partial sums of one batch item. The word goes into a cascade of multiply-add stages, one register per lane, so a new word enters every cycle. The cascade writes one lane-reduced value per word into an auxiliary buffer. Once every word of the batch is in that buffer, a serial accumulator starts each item from the bias and adds that item's NSV/LANES buffered values. It then outputs the saturated sum for the item. Items come out in ascending batch order and a done pulse closes the run.

The coefficients are held in an internal weight memory that is loaded through a write port before a run. The bias is sampled at start.

Top module: `wred_top`

## Requirements
- R1: While reset is high and after it is released, `out_valid`, `done` and `ps_rd_en` are low until a start is accepted.
- R2: The result for batch item b is bias + sum over j of w[j]*p[b][j], computed with signed arithmetic. Memory word address b*GROUPS+g holds p[b][g*LANES+k] in bits [k*PSW +: PSW]. Weight word g holds w[g*LANES+k] in bits [k*WW +: WW]. Here GROUPS = NSV/LANES.
- R3: Each run gives exactly BATCH output pulses, one per batch item, in ascending batch order.
- R4: `ps_rd_en` is high for BATCH*GROUPS consecutive cycles. It starts in the cycle after the start is sampled. The addresses run upward from 0 by one per cycle.
- R5: The multiply-add cascade takes a new word every cycle and writes the auxiliary buffer once per word, in address order, with no more than BATCH*GROUPS writes per run.
- R6: Each batch item's sum starts from the bias sampled at start, so all-zero partial sums give outputs equal to the bias.
- R7: Consecutive result pulses are exactly GROUPS cycles apart.
- R8: A sum above 2^(OW-1)-1 is output as 2^(OW-1)-1. A sum below -2^(OW-1) is output as -2^(OW-1).
- R9: `done` is a one-cycle pulse in the cycle after the last result pulse, and the block then stays quiet until the next start.
- R10: A start pulse or a bias change while a run is in progress has no effect on that run's results or count.
- R11: The serial stage reads the auxiliary buffer only after all BATCH*GROUPS entries of the run have been written. The first result therefore comes at least LANES+GROUPS+2 cycles after the last memory read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begins a run when idle |
| bias_in | input | OW | Signed bias, sampled at start |
| done | output | 1 | One-cycle end-of-run pulse |
| ps_rd_en | output | 1 | Partial-sum memory read enable |
| ps_rd_addr | output | AW | Partial-sum word address (batch*GROUPS+group) |
| ps_rd_data | input | LANES*PSW | Word returned one cycle after the read |
| wt_we | input | 1 | Weight memory write enable |
| wt_waddr | input | GW | Weight word (group) address |
| wt_wdata | input | LANES*WW | Packed signed coefficients of one group |
| out_valid | output | 1 | Result strobe, one per batch item |
| out_data | output | OW | Saturated signed result |

## Verification
The assertions assume that the partial-sum memory returns each word exactly one cycle after the read. They also assume that the weight memory is not written while a run is in progress. The bench models the memory as a registered read and loads all coefficients between runs while the block is idle. The cascade-fill checks assume that only one run is in flight at a time. The bench keeps to this by pulsing start only while the block is idle, except in the scenario that deliberately pokes start mid-run to show it is ignored.

// File: rtl/wred_pkg.sv
package wred_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_FEED,
    ST_DRAIN,
    ST_REDUCE
  } wred_state_e;
endpackage

// File: rtl/wred_wmem.sv
module wred_wmem #(
  parameter int DEPTH = 4,
  parameter int DW    = 64,
  parameter int AW    = 2
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/wred_auxbuf.sv
module wred_auxbuf #(
  parameter int DEPTH = 8,
  parameter int DW    = 59,
  parameter int AW    = 3
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/wred_chain.sv
module wred_chain #(
  parameter int LANES = 4,
  parameter int PSW   = 40,
  parameter int WW    = 16,
  parameter int TW    = 3,
  parameter int ACCW  = 59
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               in_valid,
  input  logic [TW-1:0]      in_tag,
  input  logic [LANES*PSW-1:0] in_ps,
  input  logic [LANES*WW-1:0]  in_wt,
  output logic               out_valid,
  output logic [TW-1:0]      out_tag,
  output logic [ACCW-1:0]    out_sum
);
  localparam int PROD = PSW + WW;

  logic [LANES-1:0]           vld_q;
  logic [TW-1:0]              tag_q [LANES];
  logic [ACCW-1:0]            sum_q [LANES];
  logic [LANES*PSW-1:0]       ps_q  [LANES];
  logic [LANES*WW-1:0]        wt_q  [LANES];
  logic [LANES-1:0][PROD-1:0] prod_w;

  // Lane k multiplies operands that have travelled k stages with the running sum
  for (genvar k = 0; k < LANES; k++) begin : g_lane
    logic [PSW-1:0] p_l;
    logic [WW-1:0]  w_l;
    if (k == 0) begin : g_src_in
      assign p_l = in_ps[0 +: PSW];
      assign w_l = in_wt[0 +: WW];
    end else begin : g_src_stage
      assign p_l = ps_q[k-1][k*PSW +: PSW];
      assign w_l = wt_q[k-1][k*WW +: WW];
    end
    assign prod_w[k] = PROD'($signed(PROD'($signed(p_l))) * $signed(PROD'($signed(w_l))));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      vld_q <= '0;
    end else begin
      vld_q[0] <= in_valid;
      for (int k = 1; k < LANES; k++) vld_q[k] <= vld_q[k-1];
    end
  end

  always_ff @(posedge clk) begin
    sum_q[0] <= ACCW'($signed(prod_w[0]));
    ps_q[0]  <= in_ps;
    wt_q[0]  <= in_wt;
    tag_q[0] <= in_tag;
    for (int k = 1; k < LANES; k++) begin
      sum_q[k] <= sum_q[k-1] + ACCW'($signed(prod_w[k]));
      ps_q[k]  <= ps_q[k-1];
      wt_q[k]  <= wt_q[k-1];
      tag_q[k] <= tag_q[k-1];
    end
  end

  assign out_valid = vld_q[LANES-1];
  assign out_tag   = tag_q[LANES-1];
  assign out_sum   = sum_q[LANES-1];
endmodule

// File: rtl/wred_top.sv
module wred_top
  import wred_pkg::*;
#(
  parameter int LANES = 4,
  parameter int NSV   = 16,
  parameter int BATCH = 2,
  parameter int PSW   = 40,
  parameter int WW    = 16,
  parameter int OW    = 48,
  localparam int GROUPS = NSV / LANES,
  localparam int AUXN   = BATCH * GROUPS,
  localparam int AW     = (AUXN > 1) ? $clog2(AUXN) : 1,
  localparam int GW     = (GROUPS > 1) ? $clog2(GROUPS) : 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 start,
  input  logic [OW-1:0]        bias_in,
  output logic                 done,
  output logic                 ps_rd_en,
  output logic [AW-1:0]        ps_rd_addr,
  input  logic [LANES*PSW-1:0] ps_rd_data,
  input  logic                 wt_we,
  input  logic [GW-1:0]        wt_waddr,
  input  logic [LANES*WW-1:0]  wt_wdata,
  output logic                 out_valid,
  output logic [OW-1:0]        out_data
);
  localparam int ACCW = PSW + WW + ((LANES > 1) ? $clog2(LANES) : 0) + 1;
  localparam int SUMW = ACCW + GW + 1;

  wred_state_e           state_q;
  logic [OW-1:0]         bias_q;
  logic [GW-1:0]         feed_grp_q;
  logic                  d1_vld_q;
  logic [AW-1:0]         d1_tag_q;
  logic [LANES*WW-1:0]   wt_rdata;
  logic                  ch_vld;
  logic [AW-1:0]         ch_tag;
  logic [ACCW-1:0]       ch_sum;
  logic [AW:0]           wr_cnt_q;
  logic                  rd_en_q;
  logic [AW-1:0]         rd_ptr_q;
  logic [GW-1:0]         rd_grp_q;
  logic                  rd_vld_q;
  logic [GW-1:0]         rv_grp_q;
  logic                  rv_last_q;
  logic [ACCW-1:0]       aux_rdata;
  logic signed [SUMW-1:0] acc_q;
  logic signed [SUMW-1:0] acc_nx;
  logic                  out_last_q;

  function automatic logic [OW-1:0] clamp_out(input logic signed [SUMW-1:0] v);
    if (v[SUMW-1:OW-1] == {(SUMW-OW+1){v[SUMW-1]}}) return v[OW-1:0];
    else if (v[SUMW-1]) return {1'b1, {(OW-1){1'b0}}};
    else return {1'b0, {(OW-1){1'b1}}};
  endfunction

  wred_wmem #(.DEPTH(GROUPS), .DW(LANES*WW), .AW(GW)) u_wmem (
    .clk(clk), .we(wt_we), .waddr(wt_waddr), .wdata(wt_wdata),
    .re(ps_rd_en), .raddr(feed_grp_q), .rdata(wt_rdata)
  );

  wred_chain #(.LANES(LANES), .PSW(PSW), .WW(WW), .TW(AW), .ACCW(ACCW)) u_chain (
    .clk(clk), .rst(rst), .in_valid(d1_vld_q), .in_tag(d1_tag_q),
    .in_ps(ps_rd_data), .in_wt(wt_rdata),
    .out_valid(ch_vld), .out_tag(ch_tag), .out_sum(ch_sum)
  );

  wred_auxbuf #(.DEPTH(AUXN), .DW(ACCW), .AW(AW)) u_aux (
    .clk(clk), .we(ch_vld), .waddr(ch_tag), .wdata(ch_sum),
    .re(rd_en_q), .raddr(rd_ptr_q), .rdata(aux_rdata)
  );

  // Serial stage: first group of each item starts from the bias
  always_comb begin
    acc_nx = ((rv_grp_q == '0) ? SUMW'($signed(bias_q)) : acc_q) + SUMW'($signed(aux_rdata));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= ST_IDLE;
      bias_q     <= '0;
      ps_rd_en   <= 1'b0;
      ps_rd_addr <= '0;
      feed_grp_q <= '0;
      d1_vld_q   <= 1'b0;
      d1_tag_q   <= '0;
      wr_cnt_q   <= '0;
      rd_en_q    <= 1'b0;
      rd_ptr_q   <= '0;
      rd_grp_q   <= '0;
      rd_vld_q   <= 1'b0;
      rv_grp_q   <= '0;
      rv_last_q  <= 1'b0;
      acc_q      <= '0;
      out_valid  <= 1'b0;
      out_data   <= '0;
      out_last_q <= 1'b0;
      done       <= 1'b0;
    end else begin
      done      <= 1'b0;
      out_valid <= 1'b0;
      d1_vld_q  <= ps_rd_en;
      d1_tag_q  <= ps_rd_addr;
      rd_vld_q  <= rd_en_q;
      rv_grp_q  <= rd_grp_q;
      rv_last_q <= (rd_ptr_q == AW'(AUXN-1));
      if (ch_vld) wr_cnt_q <= wr_cnt_q + 1'b1;
      case (state_q)
        ST_IDLE: begin
          if (start) begin
            bias_q     <= bias_in;
            ps_rd_en   <= 1'b1;
            ps_rd_addr <= '0;
            feed_grp_q <= '0;
            wr_cnt_q   <= '0;
            state_q    <= ST_FEED;
          end
        end
        ST_FEED: begin
          if (ps_rd_addr == AW'(AUXN-1)) begin
            ps_rd_en <= 1'b0;
            state_q  <= ST_DRAIN;
          end else begin
            ps_rd_addr <= ps_rd_addr + 1'b1;
            feed_grp_q <= (feed_grp_q == GW'(GROUPS-1)) ? '0 : feed_grp_q + 1'b1;
          end
        end
        ST_DRAIN: begin
          if (wr_cnt_q == (AW+1)'(AUXN)) begin
            rd_en_q  <= 1'b1;
            rd_ptr_q <= '0;
            rd_grp_q <= '0;
            state_q  <= ST_REDUCE;
          end
        end
        ST_REDUCE: begin
          if (rd_en_q) begin
            if (rd_ptr_q == AW'(AUXN-1)) begin
              rd_en_q <= 1'b0;
            end else begin
              rd_ptr_q <= rd_ptr_q + 1'b1;
              rd_grp_q <= (rd_grp_q == GW'(GROUPS-1)) ? '0 : rd_grp_q + 1'b1;
            end
          end
          if (rd_vld_q) begin
            acc_q <= acc_nx;
            if (rv_grp_q == GW'(GROUPS-1)) begin
              out_valid  <= 1'b1;
              out_data   <= clamp_out(acc_nx);
              out_last_q <= rv_last_q;
            end
          end
          if (out_valid && out_last_q) begin
            done    <= 1'b1;
            state_q <= ST_IDLE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  AST_RD_ADDR_STEP: assert property (@(posedge clk) disable iff (rst)
    ps_rd_en && $past(ps_rd_en) |-> ps_rd_addr == AW'($past(ps_rd_addr) + 1'b1)); // R4
  AST_FILL_STEP: assert property (@(posedge clk) disable iff (rst)
    ch_vld && $past(ch_vld) |-> ch_tag == AW'($past(ch_tag) + 1'b1)); // R5
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    ch_vld |-> wr_cnt_q < (AW+1)'(AUXN)); // R5
  AST_REDUCE_AFTER_FILL: assert property (@(posedge clk) disable iff (rst)
    rd_en_q |-> wr_cnt_q == (AW+1)'(AUXN)); // R11
  AST_DONE_AFTER_LAST: assert property (@(posedge clk) disable iff (rst)
    done |-> $past(out_valid)); // R9
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R9
endmodule

// File: tb/tb_wred_top.sv
module tb_wred_top;
  localparam int LANES = 4, NSV = 16, BATCH = 2, PSW = 40, WW = 16, OW = 48;
  localparam int GROUPS = NSV / LANES;
  localparam int AUXN = BATCH * GROUPS;
  localparam int AW = (AUXN > 1) ? $clog2(AUXN) : 1;
  localparam int GW = (GROUPS > 1) ? $clog2(GROUPS) : 1;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst, start, done, ps_rd_en, wt_we, out_valid;
  logic [OW-1:0] bias_in, out_data;
  logic [AW-1:0] ps_rd_addr;
  logic [LANES*PSW-1:0] ps_rd_data;
  logic [GW-1:0] wt_waddr;
  logic [LANES*WW-1:0] wt_wdata;

  wred_top #(.LANES(LANES), .NSV(NSV), .BATCH(BATCH), .PSW(PSW), .WW(WW), .OW(OW)) dut (
    .clk(clk), .rst(rst), .start(start), .bias_in(bias_in), .done(done),
    .ps_rd_en(ps_rd_en), .ps_rd_addr(ps_rd_addr), .ps_rd_data(ps_rd_data),
    .wt_we(wt_we), .wt_waddr(wt_waddr), .wt_wdata(wt_wdata),
    .out_valid(out_valid), .out_data(out_data)
  );

  logic [LANES*PSW-1:0] psmem [AUXN];
  always @(posedge clk) if (ps_rd_en) ps_rd_data <= psmem[ps_rd_addr];

  longint wv [NSV];
  longint pv [BATCH][NSV];
  longint expv [BATCH];
  int checks = 0;
  int fails = 0;

  task automatic chk(input bit ok, input string req, input string what, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic longint clamp(input longint v);
    longint hi = (64'sd1 <<< (OW-1)) - 1;
    longint lo = -(64'sd1 <<< (OW-1));
    if (v > hi) return hi;
    if (v < lo) return lo;
    return v;
  endfunction

  task automatic load_all();
    for (int g = 0; g < GROUPS; g++) begin
      logic [LANES*WW-1:0] w;
      for (int k = 0; k < LANES; k++) begin
        longint t = wv[g*LANES+k];
        w[k*WW +: WW] = t[WW-1:0];
      end
      wt_we = 1'b1; wt_waddr = GW'(g); wt_wdata = w;
      @(negedge clk);
    end
    wt_we = 1'b0;
    for (int b = 0; b < BATCH; b++)
      for (int g = 0; g < GROUPS; g++) begin
        logic [LANES*PSW-1:0] word;
        for (int k = 0; k < LANES; k++) begin
          longint t = pv[b][g*LANES+k];
          word[k*PSW +: PSW] = t[PSW-1:0];
        end
        psmem[b*GROUPS+g] = word;
      end
  endtask

  task automatic run(input longint bias_v, input bit poke, input string req);
    int n, rd_cnt, rd_bad, first_rd, last_rd, k, done_cnt, done_n, extras;
    int out_n [BATCH];
    longint got [BATCH];
    rd_cnt = 0; rd_bad = 0; first_rd = -1; last_rd = -1; k = 0;
    done_cnt = 0; done_n = -1; extras = 0;
    for (int b = 0; b < BATCH; b++) begin
      out_n[b] = 0; got[b] = 0;
      expv[b] = bias_v;
      for (int j = 0; j < NSV; j++) expv[b] += wv[j] * pv[b][j];
      expv[b] = clamp(expv[b]);
    end
    load_all();
    @(negedge clk);
    bias_in = bias_v[OW-1:0];
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    n = 1;
    while (done_cnt == 0 && n < 3000) begin
      if (ps_rd_en) begin
        if (first_rd < 0) first_rd = n;
        if (ps_rd_addr != AW'(rd_cnt) || n != first_rd + rd_cnt) rd_bad++;
        rd_cnt++;
        last_rd = n;
      end
      if (out_valid) begin
        if (k < BATCH) begin
          got[k] = longint'($signed(out_data));
          out_n[k] = n;
        end
        k++;
      end
      if (done) begin
        done_cnt++;
        done_n = n;
      end
      if (poke && (n == 3 || n == 12)) begin
        start = 1'b1;
        bias_in = ~bias_in;
      end else begin
        start = 1'b0;
      end
      if (done_cnt == 0) begin
        @(negedge clk);
        n++;
      end
    end
    start = 1'b0;
    repeat (8) begin
      @(negedge clk);
      if (ps_rd_en || out_valid || done) extras++;
    end
    chk(k == BATCH, "R3", "result pulse count", k, BATCH);
    for (int b = 0; b < BATCH; b++)
      chk(got[b] == expv[b], req, $sformatf("item %0d value", b), got[b], expv[b]);
    chk(rd_cnt == AUXN, "R4", "read count", rd_cnt, AUXN);
    chk(rd_bad == 0 && first_rd == 1, "R4", "read order/first cycle", first_rd, 1);
    for (int b = 1; b < BATCH; b++)
      chk(out_n[b] - out_n[b-1] == GROUPS, "R7", "result spacing", out_n[b] - out_n[b-1], GROUPS);
    chk(out_n[0] - last_rd >= LANES + GROUPS + 2, "R11", "first result after fill",
        out_n[0] - last_rd, LANES + GROUPS + 2);
    chk(done_cnt == 1 && done_n == out_n[BATCH-1] + 1, "R9", "done cycle", done_n, out_n[BATCH-1] + 1);
    chk(extras == 0, poke ? "R10" : "R9", "activity after done", extras, 0);
  endtask

  task automatic t_reset();
    rst = 1'b1; start = 1'b0; bias_in = '0; wt_we = 1'b0; wt_waddr = '0; wt_wdata = '0;
    repeat (3) @(negedge clk);
    chk(out_valid == 1'b0, "R1", "out_valid in reset", longint'(out_valid), 0);
    chk(done == 1'b0, "R1", "done in reset", longint'(done), 0);
    rst = 1'b0;
    repeat (2) @(negedge clk);
    chk(ps_rd_en == 1'b0 && out_valid == 1'b0, "R1", "idle after reset", longint'(ps_rd_en), 0);
  endtask

  task automatic fill_random();
    for (int j = 0; j < NSV; j++) begin
      wv[j] = longint'($urandom_range(0, 8191)) - 4096;
      for (int b = 0; b < BATCH; b++) pv[b][j] = longint'($urandom_range(0, 2097151)) - 1048576;
    end
  endtask

  task automatic t_basic();
    fill_random();
    run(12345, 1'b0, "R2");
  endtask

  task automatic t_mapping();
    for (int j = 0; j < NSV; j++) begin
      wv[j] = j + 1;
      for (int b = 0; b < BATCH; b++) pv[b][j] = 0;
    end
    pv[0][3] = 1000;
    pv[BATCH-1][NSV-3] = -2000;
    run(-50, 1'b0, "R2");
  endtask

  task automatic t_bias_only();
    fill_random();
    for (int j = 0; j < NSV; j++)
      for (int b = 0; b < BATCH; b++) pv[b][j] = 0;
    run(-777, 1'b0, "R6");
  endtask

  task automatic t_sat();
    for (int j = 0; j < NSV; j++) begin
      wv[j] = 32767;
      for (int b = 0; b < BATCH; b++) pv[b][j] = (64'sd1 <<< (PSW-1)) - 1;
    end
    run(0, 1'b0, "R8");
    for (int j = 0; j < NSV; j++) begin
      wv[j] = -32768;
      pv[BATCH-1][j] = 0;
    end
    run(5, 1'b0, "R8");
  endtask

  task automatic t_busy_start();
    fill_random();
    run(999, 1'b1, "R10");
  endtask

  initial begin
    t_reset();
    t_basic();
    t_mapping();
    t_bias_only();
    t_sat();
    t_busy_start();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL R3 watchdog expired actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule